// File: doc/BRIEF.md
# Strobed Handshake Parallel Port Group

This block is one programmable parallel I/O group. It has an 8-bit data port and an 8-bit companion port that carries handshake and status bits. A host bus writes control words to set the operating mode or to change one companion bit, and it reads or writes data through the port addresses. In the plain modes the data port is a latched output or a live input. In the strobed modes, an external strobe and acknowledge pace the transfers. Buffer-full flags and one interrupt request report the state of each transfer.

The host strobes `rd_n` and `wr_n`, and the external strobes `stb_n` and `ack_n`, are asynchronous. Each one passes through a synchronizer clocked by `clk`, and the block acts on the edges it detects there. A flag changes on the third rising clock edge after the pin edge that causes it. The host must hold `addr` and `wdata` stable from the start of a write strobe until at least four clocks after the strobe ends. It must hold `addr` stable through a read strobe. Read data is combinational from `addr` and the current state.

Top module: `hpio_group`

## Requirements
- R1: After reset the group is in plain input mode. `pa_oe`=0, `pa_out`=0, `pc_out`=0 and `irq`=0.
- R2: A write to a control address (`addr[1]`=1) with `wdata[7]`=1 is a mode word. `wdata[6:5]`=01 selects strobed operation, and any other value selects plain operation. `wdata[4]`=1 makes the data port an input and 0 makes it an output. A mode word clears the data output latch, the companion latch, the interrupt enable, the input-full flag and `irq`, and it makes the output-full flag inactive (companion bit 1 reads 1 in strobed output mode). `pa_oe` is 1 exactly in the output modes.
- R3: A control write with `wdata[7]`=0 is a bit word. `wdata[3:1]` selects a companion bit and `wdata[0]` is its new value. Bits that are not handshake positions change in the companion latch and appear on `pc_out` and on a read of address 1.
- R4: In strobed input mode, `stb_n` falling loads `pa_in` into the input latch and sets the input-full flag (companion bit 5). A read of address 0 returns the latched value, not the live pins.
- R5: In strobed input mode, `stb_n` rising sets `irq` (companion bit 3) only when the input-full flag and the input interrupt enable are both 1. The input interrupt enable is bit word select 4. It reads back at companion bit 4 and drives 0 on `pc_out[4]`.
- R6: In strobed input mode, `rd_n` falling at address 0 clears `irq`, and `rd_n` rising at address 0 clears the input-full flag.
- R7: In strobed output mode, `wr_n` rising at address 0 loads `pa_out` and drives the active-low output-full line (companion bit 1) to 0. `ack_n` falling returns that line to 1.
- R8: In strobed output mode, `ack_n` rising sets `irq` (companion bit 0) only when the output interrupt enable is 1, and `wr_n` falling at address 0 clears `irq`. The output interrupt enable is bit word select 2. It reads back at companion bit 2 and drives 0 on `pc_out[2]`.
- R9: Bit words and companion writes never change a handshake flag. In strobed input mode the handshake positions are bits 5, 4 and 3. In strobed output mode they are bits 2, 1 and 0.
- R10: In the plain modes, `irq` stays 0 and strobe or acknowledge pulses have no effect. In plain input mode a read of address 0 returns `pa_in` directly.
- R11: A write to address 1 loads only the companion bits that are not handshake positions in the current mode. In plain modes it loads all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Host address: 0 data, 1 companion, 2 or 3 control |
| wdata | input | 8 | Host write data |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rdata | output | 8 | Host read data; 0 for control addresses |
| pa_in | input | 8 | Data port input pins |
| pa_out | output | 8 | Data port output latch |
| pa_oe | output | 1 | Data port drives its pins |
| stb_n | input | 1 | Input strobe, active low |
| ack_n | input | 1 | Output acknowledge, active low |
| pc_out | output | 8 | Companion port: general bits and handshake flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the edge-driven flag rules on every cycle:
- a mode word clearing the latch and `irq`;
- a strobe setting the input-full flag;
- a read or write strobe clearing `irq`;
- a write strobe and an acknowledge driving the output-full line low and high;
- `irq` rising only one cycle after a strobe or acknowledge rising edge;
- `irq` staying 0 in the plain modes.

Only the bench scenarios can show the data that moves:
- the value captured at the strobe being returned, rather than the live pins;
- bit words aimed at handshake positions being ignored;
- the companion-write masks and the interrupt enables, whose effect appears only at a later strobe.

// File: rtl/hpio_pkg.sv
package hpio_pkg;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int SELW = $clog2(CW);

  // encoding is {strobed, input}
  typedef enum logic [1:0] {
    MD_PLAIN_OUT = 2'b00,
    MD_PLAIN_IN  = 2'b01,
    MD_STB_OUT   = 2'b10,
    MD_STB_IN    = 2'b11
  } mode_e;

  localparam int IN_INTR_BIT  = 3;
  localparam int IN_INTE_BIT  = 4;
  localparam int IN_IBF_BIT   = 5;
  localparam int OUT_INTR_BIT = 0;
  localparam int OUT_OBF_BIT  = 1;
  localparam int OUT_INTE_BIT = 2;

  function automatic logic [CW-1:0] hs_mask(mode_e m);
    logic [CW-1:0] r;
    r = '0;
    if (m == MD_STB_IN) begin
      r[IN_INTR_BIT] = 1'b1;
      r[IN_INTE_BIT] = 1'b1;
      r[IN_IBF_BIT]  = 1'b1;
    end else if (m == MD_STB_OUT) begin
      r[OUT_INTR_BIT] = 1'b1;
      r[OUT_OBF_BIT]  = 1'b1;
      r[OUT_INTE_BIT] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hpio_sync.sv
module hpio_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [STAGES-1:0][N-1:0] chain_q, chain_d;
  logic [N-1:0]             prev_q;

  always_comb begin
    chain_d[0] = din;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  // idle level of every synchronized strobe is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= '1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/hpio_cfg.sv
module hpio_cfg
  import hpio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output mode_e         mode_q,
  output logic [DW-1:0] pa_q,
  output logic [CW-1:0] pc_q,
  output logic          inte_q,
  output logic          mode_set,
  output logic          data_wr
);
  mode_e         mode_d;
  logic [DW-1:0] pa_d;
  logic [CW-1:0] pc_d, mask;
  logic          inte_d, comp_wr, bit_op, en;
  logic [SELW-1:0] sel;

  assign mode_set = wr_rise & addr[1] & wdata[7];
  assign bit_op   = wr_rise & addr[1] & ~wdata[7];
  assign data_wr  = wr_rise & (addr == 2'd0);
  assign comp_wr  = wr_rise & (addr == 2'd1);
  assign mask     = hs_mask(mode_q);
  assign sel      = wdata[3:1];
  assign en       = mode_set | bit_op | data_wr | comp_wr;

  always_comb begin
    mode_d = mode_q;
    pa_d   = pa_q;
    pc_d   = pc_q;
    inte_d = inte_q;
    if (mode_set) begin
      mode_d = mode_e'({~wdata[6] & wdata[5], wdata[4]});
      pa_d   = '0;
      pc_d   = '0;
      inte_d = 1'b0;
    end else begin
      if (data_wr) pa_d = wdata;
      if (comp_wr) pc_d = (pc_q & mask) | (wdata[CW-1:0] & ~mask);
      if (bit_op) begin
        if (mode_q == MD_STB_IN && sel == SELW'(IN_INTE_BIT))
          inte_d = wdata[0];
        else if (mode_q == MD_STB_OUT && sel == SELW'(OUT_INTE_BIT))
          inte_d = wdata[0];
        else if (!mask[sel])
          pc_d[sel] = wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_PLAIN_IN;
      pa_q   <= '0;
      pc_q   <= '0;
      inte_q <= 1'b0;
    end else if (en) begin
      mode_q <= mode_d;
      pa_q   <= pa_d;
      pc_q   <= pc_d;
      inte_q <= inte_d;
    end
  end
endmodule

// File: rtl/hpio_flags.sv
module hpio_flags
  import hpio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode_q,
  input  logic          inte_q,
  input  logic          mode_set,
  input  logic          data_wr,
  input  logic          data_wr_fall,
  input  logic          data_rd_fall,
  input  logic          data_rd_rise,
  input  logic          stb_fall,
  input  logic          stb_rise,
  input  logic          ack_fall,
  input  logic          ack_rise,
  input  logic [DW-1:0] pa_in,
  output logic          ibf_q,
  output logic          obf_n_q,
  output logic          intr_q,
  output logic [DW-1:0] in_q
);
  logic          ibf_d, obf_n_d, intr_d, in_en;
  logic [DW-1:0] in_d;

  always_comb begin
    ibf_d   = ibf_q;
    obf_n_d = obf_n_q;
    intr_d  = intr_q;
    in_d    = in_q;
    in_en   = 1'b0;
    if (mode_set) begin
      ibf_d   = 1'b0;
      obf_n_d = 1'b1;
      intr_d  = 1'b0;
    end else if (mode_q == MD_STB_IN) begin
      if (stb_fall) begin
        in_en = 1'b1;
        in_d  = pa_in;
        ibf_d = 1'b1;
      end else if (data_rd_rise) begin
        ibf_d = 1'b0;
      end
      if (stb_rise && ibf_q && inte_q) intr_d = 1'b1;
      else if (data_rd_fall)           intr_d = 1'b0;
    end else if (mode_q == MD_STB_OUT) begin
      if (data_wr)       obf_n_d = 1'b0;
      else if (ack_fall) obf_n_d = 1'b1;
      if (ack_rise && inte_q) intr_d = 1'b1;
      else if (data_wr_fall)  intr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q   <= 1'b0;
      obf_n_q <= 1'b1;
      intr_q  <= 1'b0;
    end else begin
      ibf_q   <= ibf_d;
      obf_n_q <= obf_n_d;
      intr_q  <= intr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= '0;
    else if (in_en) in_q <= in_d;
  end
endmodule

// File: rtl/hpio_group.sv
module hpio_group
  import hpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic          pa_oe,
  input  logic          stb_n,
  input  logic          ack_n,
  output logic [CW-1:0] pc_out,
  output logic          irq
);
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [3:0] ev_rise, ev_fall;
  hpio_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .din({wr_n, rd_n, ack_n, stb_n}),
    .rise(ev_rise), .fall(ev_fall));

  logic stb_rise, stb_fall, ack_rise, ack_fall;
  logic data_rd_fall, data_rd_rise, data_wr_fall, wr_rise;
  assign stb_rise     = ev_rise[0];
  assign stb_fall     = ev_fall[0];
  assign ack_rise     = ev_rise[1];
  assign ack_fall     = ev_fall[1];
  assign data_rd_rise = ev_rise[2] & (addr == 2'd0);
  assign data_rd_fall = ev_fall[2] & (addr == 2'd0);
  assign wr_rise      = ev_rise[3];
  assign data_wr_fall = ev_fall[3] & (addr == 2'd0);

  mode_e         mode_q;
  logic [DW-1:0] pa_q, in_q;
  logic [CW-1:0] pc_q, comp_rb;
  logic          inte_q, mode_set, data_wr, ibf_q, obf_n_q, intr_q;

  hpio_cfg u_cfg (
    .clk(clk), .rst_n(rst_q), .wr_rise(wr_rise), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .pa_q(pa_q), .pc_q(pc_q), .inte_q(inte_q),
    .mode_set(mode_set), .data_wr(data_wr));

  hpio_flags u_flags (
    .clk(clk), .rst_n(rst_q), .mode_q(mode_q), .inte_q(inte_q),
    .mode_set(mode_set), .data_wr(data_wr), .data_wr_fall(data_wr_fall),
    .data_rd_fall(data_rd_fall), .data_rd_rise(data_rd_rise),
    .stb_fall(stb_fall), .stb_rise(stb_rise), .ack_fall(ack_fall),
    .ack_rise(ack_rise), .pa_in(pa_in), .ibf_q(ibf_q), .obf_n_q(obf_n_q),
    .intr_q(intr_q), .in_q(in_q));

  always_comb begin
    comp_rb = pc_q;
    pc_out  = pc_q;
    if (mode_q == MD_STB_IN) begin
      comp_rb[IN_IBF_BIT]  = ibf_q;
      comp_rb[IN_INTE_BIT] = inte_q;
      comp_rb[IN_INTR_BIT] = intr_q;
      pc_out               = comp_rb;
      pc_out[IN_INTE_BIT]  = 1'b0;
    end else if (mode_q == MD_STB_OUT) begin
      comp_rb[OUT_OBF_BIT]  = obf_n_q;
      comp_rb[OUT_INTE_BIT] = inte_q;
      comp_rb[OUT_INTR_BIT] = intr_q;
      pc_out                = comp_rb;
      pc_out[OUT_INTE_BIT]  = 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 2'd0) begin
      case (mode_q)
        MD_STB_IN:   rdata = in_q;
        MD_PLAIN_IN: rdata = pa_in;
        default:     rdata = pa_q;
      endcase
    end else if (addr == 2'd1) begin
      rdata = comp_rb;
    end
  end

  assign pa_out = pa_q;
  assign pa_oe  = ~mode_q[0];
  assign irq    = intr_q;
endmodule

// File: rtl/hpio_group_chk.sv
module hpio_group_chk
  import hpio_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input mode_e         mode,
  input logic          mode_set,
  input logic          data_wr,
  input logic          wr_fall_data,
  input logic          rd_fall_data,
  input logic          stb_fall,
  input logic          stb_rise,
  input logic          ack_fall,
  input logic          ack_rise,
  input logic [DW-1:0] pa_out,
  input logic [CW-1:0] pc_out,
  input logic          irq
);
  AST_MODESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (pa_out == '0 && !irq)); // R2
  AST_STROBE_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STB_IN && stb_fall && !mode_set) |=> pc_out[IN_IBF_BIT]); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(stb_rise || ack_rise)); // R5
  AST_READ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STB_IN && rd_fall_data && !stb_rise && !mode_set) |=> !irq); // R6
  AST_WRITE_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STB_OUT && data_wr) |=> !pc_out[OUT_OBF_BIT]); // R7
  AST_ACK_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STB_OUT && ack_fall && !data_wr && !mode_set) |=> pc_out[OUT_OBF_BIT]); // R7
  AST_WRFALL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STB_OUT && wr_fall_data && !ack_rise && !mode_set) |=> !irq); // R8
  AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PLAIN_IN || mode == MD_PLAIN_OUT) |-> !irq); // R10
endmodule

bind hpio_group hpio_group_chk u_chk (
  .clk(clk), .rst_n(rst_q), .mode(mode_q), .mode_set(mode_set),
  .data_wr(data_wr), .wr_fall_data(data_wr_fall), .rd_fall_data(data_rd_fall),
  .stb_fall(stb_fall), .stb_rise(stb_rise), .ack_fall(ack_fall),
  .ack_rise(ack_rise), .pa_out(pa_out), .pc_out(pc_out), .irq(irq));

// File: tb/hpio_group_test.sv
module hpio_group_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       rd_n = 1'b1, wr_n = 1'b1, stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] pa_in = 8'h00;
  logic [7:0] rdata, pa_out, pc_out;
  logic       pa_oe, irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  hpio_group uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .stb_n(stb_n), .ack_n(ack_n), .pc_out(pc_out), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_rd(logic [1:0] a, output logic [7:0] d, output logic irq_mid);
    @(negedge clk); addr = a; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = rdata; irq_mid = irq;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe(logic [7:0] d, output logic [7:0] pc_mid, output logic irq_mid);
    @(negedge clk); pa_in = d; stb_n = 1'b0;
    repeat (5) @(negedge clk);
    pc_mid = pc_out; irq_mid = irq;
    stb_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic acknowledge(output logic [7:0] pc_mid, output logic irq_mid);
    @(negedge clk); ack_n = 1'b0;
    repeat (5) @(negedge clk);
    pc_mid = pc_out; irq_mid = irq;
    ack_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // model of a bit word in plain mode (R3)
  function automatic logic [7:0] f_bitop(logic [7:0] pc, logic [7:0] w);
    logic [7:0] r;
    r = pc;
    r[w[3:1]] = w[0];
    return r;
  endfunction

  // model of a companion write under a handshake mask (R11)
  function automatic logic [7:0] f_compwr(logic [7:0] pc, logic [7:0] w, logic [7:0] m);
    return (pc & m) | (w & ~m);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, pcm, exp_pa, exp_pc;
    logic       im;
    int unsigned r;
    r = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // plain output, random traffic
    host_wr(2'd2, 8'h80);
    chk("R2 pa_oe out", {7'd0, pa_oe}, 8'h01);
    exp_pa = 8'h00; exp_pc = 8'h00;
    for (int i = 0; i < 40; i++) begin
      r = $urandom;
      d = 8'($urandom);
      case (r % 3)
        0: begin host_wr(2'd0, d); exp_pa = d; end
        1: begin host_wr(2'd2, {4'h0, d[3:0]}); exp_pc = f_bitop(exp_pc, {4'h0, d[3:0]}); end
        default: begin host_wr(2'd1, d); exp_pc = f_compwr(exp_pc, d, 8'h00); end
      endcase
      chk("R10 plain pa_out", pa_out, exp_pa);
      chk("R3 pc_out", pc_out, exp_pc);
      if (i % 8 == 0) begin
        host_rd(2'd1, d, im);
        chk("R11 companion readback", d, exp_pc);
      end
    end
    host_wr(2'd0, 8'h5C);
    host_wr(2'd1, 8'hF3);
    acknowledge(pcm, im);
    chk("R10 ack ignored irq", {7'd0, irq}, 8'h00);
    chk("R10 ack ignored pc", pc_out, 8'hF3);
    host_wr(2'd2, 8'h80);
    chk("R2 clears pa", pa_out, 8'h00);
    chk("R2 clears pc", pc_out, 8'h00);

    // plain input
    host_wr(2'd2, 8'h90);
    chk("R2 pa_oe in", {7'd0, pa_oe}, 8'h00);
    pa_in = 8'h3C;
    host_rd(2'd0, d, im);
    chk("R10 live read 1", d, 8'h3C);
    pa_in = 8'hC3;
    host_rd(2'd0, d, im);
    chk("R10 live read 2", d, 8'hC3);
    strobe(8'h12, pcm, im);
    chk("R10 strobe ignored", {7'd0, irq}, 8'h00);
    chk("R10 strobe no flag", pc_out, 8'h00);

    // reserved mode field selects plain operation
    host_wr(2'd2, 8'hF0);
    strobe(8'h44, pcm, im);
    chk("R2 reserved is plain irq", {7'd0, irq}, 8'h00);
    host_rd(2'd0, d, im);
    chk("R2 reserved is plain read", d, 8'h44);

    // strobed input
    host_wr(2'd2, 8'hB0);
    host_wr(2'd2, 8'h09);
    chk("R5 inte pin drives 0", pc_out, 8'h00);
    host_rd(2'd1, d, im);
    chk("R5 inte readback", d, 8'h10);
    strobe(8'h5A, pcm, im);
    chk("R4 ibf set at strobe", pcm, 8'h20);
    chk("R5 no irq while low", {7'd0, im}, 8'h00);
    chk("R5 irq after strobe", pc_out, 8'h28);
    chk("R5 irq pin", {7'd0, irq}, 8'h01);
    pa_in = 8'hFF;
    host_rd(2'd0, d, im);
    chk("R4 latched data", d, 8'h5A);
    chk("R6 read fall drops irq", {7'd0, im}, 8'h00);
    chk("R6 read rise drops ibf", pc_out, 8'h00);
    strobe(8'h66, pcm, im);
    host_wr(2'd2, 8'h0A);
    host_wr(2'd2, 8'h06);
    chk("R9 flags untouched", pc_out, 8'h28);
    host_wr(2'd2, 8'h0F);
    chk("R3 general bit 7", pc_out, 8'hA8);
    host_rd(2'd0, d, im);
    chk("R4 second capture", d, 8'h66);
    chk("R6 flags cleared", pc_out, 8'h80);
    host_wr(2'd1, 8'hFF);
    chk("R11 masked write", pc_out, 8'hC7);
    host_rd(2'd1, d, im);
    chk("R11 readback", d, 8'hD7);
    host_wr(2'd2, 8'h08);
    strobe(8'h99, pcm, im);
    chk("R5 disabled no irq", {7'd0, irq}, 8'h00);
    chk("R5 disabled ibf", pc_out, 8'hE7);
    host_rd(2'd0, d, im);
    chk("R4 third capture", d, 8'h99);

    // strobed output
    host_wr(2'd2, 8'hA0);
    chk("R2 out pa cleared", pa_out, 8'h00);
    chk("R2 out pa_oe", {7'd0, pa_oe}, 8'h01);
    chk("R2 obf inactive", pc_out, 8'h02);
    host_wr(2'd2, 8'h05);
    host_rd(2'd1, d, im);
    chk("R8 inte readback", d, 8'h06);
    host_wr(2'd0, 8'h77);
    chk("R7 data out", pa_out, 8'h77);
    chk("R7 obf low", pc_out, 8'h00);
    acknowledge(pcm, im);
    chk("R7 ack returns obf", pcm, 8'h02);
    chk("R8 no irq while ack low", {7'd0, im}, 8'h00);
    chk("R8 irq after ack", pc_out, 8'h03);
    host_wr(2'd0, 8'h11);
    chk("R8 write drops irq", {7'd0, irq}, 8'h00);
    chk("R7 obf low again", pc_out, 8'h00);
    host_wr(2'd2, 8'h03);
    host_wr(2'd2, 8'h01);
    chk("R9 out flags untouched", pc_out, 8'h00);
    host_wr(2'd2, 8'h0D);
    chk("R3 general bit 6", pc_out, 8'h40);
    host_wr(2'd2, 8'h04);
    acknowledge(pcm, im);
    chk("R8 disabled no irq", {7'd0, irq}, 8'h00);
    chk("R7 obf high", pc_out, 8'h42);
    host_rd(2'd0, d, im);
    chk("R7 out readback", d, 8'h11);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule